// File: doc/BRIEF.md
# BCH8 Sector Parity Encoder

This block computes the 104 parity bits of a binary BCH code that corrects up to eight bit errors. The code is built over GF(2^13). Data reaches the block as a stream of bytes: a valid strobe qualifies each byte, a start flag marks the first byte of a sector and a last flag marks its final byte. The block takes one byte per clock and has no dead cycles between sectors. Inside, a 104-bit remainder register is advanced eight bits per cycle, so a 512-byte sector costs 512 accepted beats.

When the last byte has been absorbed, the block lays the remainder out as thirteen bytes, most significant coefficient first. It XORs each byte with a fixed constant byte and publishes the result on `ecc_out` together with a one-cycle `ecc_done` pulse. The constant is chosen so that an erased sector's parity field reads as all ones, matching unwritten flash. The published value stays put until the next sector completes, so a write path can copy it into the spare area at leisure.

Top module: `bch8_sector_enc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After reset, `ecc_out` reads 0 and `ecc_done` reads 0.
- R2: After a sector completes, `ecc_out` equals R(x) XOR the mask. R(x) is M(x)·x^104 mod g(x). M(x) takes bits most significant first: bit 7 of the first byte is the highest-degree coefficient. g(x) is the degree-104 product of the minimal polynomials of α^1, α^3, …, α^15, where α is a root of x^13+x^4+x^3+x+1. Byte k (k = 0..12) of the field sits at `ecc_out[103-8k -: 8]`, and byte 0 holds the coefficients of x^103 down to x^96. The mask bytes, from byte 0 to byte 12, are ef 51 2e 09 ed 93 9a c2 97 79 e5 24 b5.
- R3: A byte accepted with `in_start` high begins a fresh sector. Bytes absorbed before it have no effect on the result.
- R4: In a cycle with `in_valid` low, `in_byte`, `in_start` and `in_last` have no effect. No done pulse follows such a cycle, and no later result changes because of it.
- R5: `ecc_done` is high for exactly one cycle: the cycle after a byte is accepted with `in_last` high.
- R6: `ecc_out` changes only in a cycle where `ecc_done` is high. At all other times it holds, including while the next sector streams in.
- R7: A byte accepted with both `in_start` and `in_last` high is a complete one-byte sector. A single zero byte yields exactly the mask.
- R8: The first byte of a new sector may be accepted in the same cycle that `ecc_done` reports the previous sector. Both results are correct.
- R9: A 512-byte sector of zeros yields exactly the mask, ef 51 2e 09 ed 93 9a c2 97 79 e5 24 b5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the byte and flags in this cycle |
| in_start | input | 1 | This byte is the first of a sector |
| in_last | input | 1 | This byte is the last of a sector |
| in_byte | input | 8 | Data byte, absorbed most significant bit first |
| ecc_out | output | 104 | Masked parity field, byte 0 in bits 103:96 |
| ecc_done | output | 1 | One-cycle pulse when `ecc_out` has just been updated |

## Verification
Two pairs of functions can land in the same cycle. The first is publishing one sector's result while clearing the remainder for the next sector. The bench provokes this by driving the start byte of a second sector on the exact cycle that `ecc_done` reports the first. At that cycle it checks the first parity against the bench's long-division model, and it checks the second parity when that sector ends. The second pair is clearing and finishing on one byte. The bench drives single-byte sectors with both flags high and compares each result to the model. Random sectors with idle gaps, in which the flags and data are toggled while valid is low, are checked the same way.

// File: rtl/bch8_enc_pkg.sv
// Shared constants and elaboration-time math for the BCH8 sector encoder.
// Assumes: binary BCH over GF(2^13), designed distance 17 (t = 8).
package bch8_enc_pkg;

    localparam int GF_M      = 13;
    localparam int GF_N      = (1 << GF_M) - 1;
    localparam int CORR_T    = 8;
    localparam int BYTE_W    = 8;
    localparam int PAR_BITS  = GF_M * CORR_T;
    localparam int PAR_BYTES = PAR_BITS / BYTE_W;

    // Field polynomial x^13 + x^4 + x^3 + x + 1
    localparam logic [GF_M:0] GF_POLY = 14'h201b;

    // Constant applied to the parity so an erased sector reads as all ones
    localparam logic [PAR_BITS-1:0] ECC_MASK = 104'hef512e09ed939ac29779e524b5;

    // Multiply two field elements, shift-and-reduce from the top bit down
    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                               input logic [GF_M-1:0] b);
        logic [GF_M:0] p;
        p = '0;
        for (int i = GF_M - 1; i >= 0; i--) begin
            p = {p[GF_M-1:0], 1'b0};
            if (p[GF_M]) p = p ^ GF_POLY;
            if (b[i]) p = p ^ {1'b0, a};
        end
        return p[GF_M-1:0];
    endfunction

    // alpha raised to e, square-and-multiply over the exponent bits
    function automatic logic [GF_M-1:0] gf_pow(input logic [GF_M-1:0] e);
        logic [GF_M-1:0] r;
        logic [GF_M-1:0] base;
        r    = GF_M'(1);
        base = GF_M'(2);
        for (int i = 0; i < GF_M; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    // Generator polynomial: product of (x + alpha^e) over the conjugacy
    // classes of the odd exponents 1..2t-1; coefficients end up binary.
    function automatic logic [PAR_BITS:0] gen_poly();
        logic [(PAR_BITS+1)*GF_M-1:0] c;
        logic [GF_M-1:0]              root;
        logic [PAR_BITS:0]            g;
        int                           deg;
        int                           e;
        c           = '0;
        c[GF_M-1:0] = GF_M'(1);
        deg         = 0;
        for (int j = 1; j < 2 * CORR_T; j += 2) begin
            for (int k = 0; k < GF_M; k++) begin
                e    = (j << k) % GF_N;
                root = gf_pow(GF_M'(e));
                for (int i = deg + 1; i >= 1; i--)
                    c[i*GF_M +: GF_M] = c[(i-1)*GF_M +: GF_M] ^
                                        gf_mul(root, c[i*GF_M +: GF_M]);
                c[GF_M-1:0] = gf_mul(root, c[GF_M-1:0]);
                deg++;
            end
        end
        for (int i = 0; i <= PAR_BITS; i++) g[i] = c[i*GF_M];
        return g;
    endfunction

    localparam logic [PAR_BITS:0] GEN_POLY = gen_poly();

endpackage

// File: rtl/bch8_byte_step.sv
// Advances the parity remainder by one data byte: eight unrolled shifts of
// a premultiplied division LFSR, most significant data bit first.
// Assumes: TAPS holds the generator polynomial without its leading term.
module bch8_byte_step #(
    parameter int             W      = 104,
    parameter int             BITS   = 8,
    parameter logic [W-1:0]   TAPS   = '0
) (
    input  logic [W-1:0]    rem_in,
    input  logic [BITS-1:0] byte_in,
    output logic [W-1:0]    rem_out
);

    // Unrolled bit-serial division, one feedback per data bit
    always_comb begin
        logic [W-1:0] r;
        r = rem_in;
        for (int i = 0; i < BITS; i++) begin
            r = {r[W-2:0], 1'b0} ^ ((r[W-1] ^ byte_in[BITS-1-i]) ? TAPS : '0);
        end
        rem_out = r;
    end

endmodule

// File: rtl/bch8_ecc_format.sv
// Lays the remainder out as the parity field and applies the erased-page mask.
// Field byte 0 is the short top word (coefficients x^103..x^96); the three
// full 32-bit words follow, each high byte first.
// Assumes: W is a whole number of bytes.
module bch8_ecc_format #(
    parameter int           W    = 104,
    parameter int           BITS = 8,
    parameter logic [W-1:0] MASK = '0
) (
    input  logic [W-1:0] rem_in,
    output logic [W-1:0] ecc_out
);

    localparam int NBYTES = W / BITS;

    // One masked byte lane per field position
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign ecc_out[W-1-BITS*k -: BITS] =
            rem_in[W-1-BITS*k -: BITS] ^ MASK[W-1-BITS*k -: BITS];
    end

endmodule

// File: rtl/bch8_sector_enc.sv
// BCH8 sector parity encoder. Absorbs one byte per cycle, clears on a start
// byte, and publishes the masked parity with a done pulse one cycle after the
// last byte. The published field holds until the next sector completes.
// Assumes: the source frames sectors with start/last; no length is enforced.
module bch8_sector_enc
    import bch8_enc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_start,
    input  logic                in_last,
    input  logic [BYTE_W-1:0]   in_byte,
    output logic [PAR_BITS-1:0] ecc_out,
    output logic                ecc_done
);

    localparam logic [PAR_BITS-1:0] TAPS = GEN_POLY[PAR_BITS-1:0];

    logic [PAR_BITS-1:0] rem_q;
    logic [PAR_BITS-1:0] rem_base;
    logic [PAR_BITS-1:0] rem_next;
    logic [PAR_BITS-1:0] field_d;
    logic [PAR_BITS-1:0] field_q;
    logic                done_q;
    logic                take_last;

    // A start byte divides from a zero remainder
    assign rem_base  = (in_valid && in_start) ? '0 : rem_q;
    assign take_last = in_valid && in_last;

    bch8_byte_step #(
        .W    (PAR_BITS),
        .BITS (BYTE_W),
        .TAPS (TAPS)
    ) step_i (
        .rem_in  (rem_base),
        .byte_in (in_byte),
        .rem_out (rem_next)
    );

    bch8_ecc_format #(
        .W    (PAR_BITS),
        .BITS (BYTE_W),
        .MASK (ECC_MASK)
    ) fmt_i (
        .rem_in  (rem_next),
        .ecc_out (field_d)
    );

    // Remainder register: advances on every accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n)        rem_q <= '0;
        else if (in_valid) rem_q <= rem_next;
    end

    // Published field and done pulse: captured on the last byte only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= take_last;
            if (take_last) field_q <= field_d;
        end
    end

    assign ecc_out  = field_q;
    assign ecc_done = done_q;

endmodule

// File: rtl/bch8_sector_enc_chk.sv
// Port-level temporal checks for the BCH8 sector encoder, bound to the top.
module bch8_sector_enc_chk
    import bch8_enc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_start,
    input logic                in_last,
    input logic [BYTE_W-1:0]   in_byte,
    input logic [PAR_BITS-1:0] ecc_out,
    input logic                ecc_done
);

    // Set once a full cycle has passed out of reset, so $past is meaningful
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> ecc_done);

    assert_done_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ecc_done) |-> $past(in_valid && in_last));

    assert_field_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid && in_last)) |-> $stable(ecc_out));

    assert_idle_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !ecc_done);

    assert_zero_byte_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start && in_last && in_byte == '0) |=> (ecc_out == ECC_MASK));

endmodule

bind bch8_sector_enc bch8_sector_enc_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_last  (in_last),
    .in_byte  (in_byte),
    .ecc_out  (ecc_out),
    .ecc_done (ecc_done)
);

// File: tb/bch8_sector_enc_tb_top.sv
// Self-checking bench: random and directed sectors against a long-division model.
module bch8_sector_enc_tb_top;

    localparam logic [103:0] TB_MASK = 104'hef512e09ed939ac29779e524b5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_start = 1'b0;
    logic         in_last = 1'b0;
    logic [7:0]   in_byte = 8'h00;
    logic [103:0] ecc_out;
    logic         ecc_done;

    int           n_chk = 0;
    int           n_fail = 0;
    logic [7:0]   msg [0:511];
    logic [104:0] gen;

    always #10 clk = ~clk;

    bch8_sector_enc dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .in_last  (in_last),
        .in_byte  (in_byte),
        .ecc_out  (ecc_out),
        .ecc_done (ecc_done)
    );

    // Carry-less product, then fold the high half down
    function automatic logic [12:0] tb_mul(input logic [12:0] a, input logic [12:0] b);
        logic [25:0] p;
        p = '0;
        for (int i = 0; i < 13; i++) if (b[i]) p = p ^ (26'(a) << i);
        for (int i = 25; i >= 13; i--) if (p[i]) p = p ^ (26'(14'h201b) << (i - 13));
        return p[12:0];
    endfunction

    // Generator as a binary product of eight minimal polynomials
    function automatic logic [104:0] tb_generator();
        logic [104:0] g;
        logic [104:0] acc;
        logic [12:0]  r;
        logic [12:0]  mp [0:13];
        g = 105'd1;
        for (int j = 1; j < 16; j += 2) begin
            r = 13'd1;
            for (int i = 0; i < j; i++) r = tb_mul(r, 13'd2);
            for (int i = 0; i < 14; i++) mp[i] = (i == 0) ? 13'd1 : 13'd0;
            for (int k = 0; k < 13; k++) begin
                for (int i = 13; i >= 1; i--) mp[i] = mp[i-1] ^ tb_mul(r, mp[i]);
                mp[0] = tb_mul(r, mp[0]);
                r = tb_mul(r, r);
            end
            acc = '0;
            for (int i = 0; i < 14; i++) if (mp[i][0]) acc = acc ^ (g << i);
            g = acc;
        end
        return g;
    endfunction

    // Expected field: message followed by 104 zero bits, divided by g, masked
    function automatic logic [103:0] ref_ecc(input int n);
        logic [103:0] r;
        logic         top;
        logic         b;
        r = '0;
        for (int i = 0; i < n + 13; i++) begin
            for (int k = 7; k >= 0; k--) begin
                b   = (i < n) ? msg[i][k] : 1'b0;
                top = r[103];
                r   = {r[102:0], b};
                if (top) r = r ^ gen[103:0];
            end
        end
        return r ^ TB_MASK;
    endfunction

    task automatic chk_vec(input string req, input logic [103:0] got, input logic [103:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic put(input logic v, input logic s, input logic l, input logic [7:0] b);
        @(negedge clk);
        in_valid = v; in_start = s; in_last = l; in_byte = b;
    endtask

    // Idle beat with noisy flags and data (R4 stimulus)
    task automatic idle_noise();
        put(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom));
    endtask

    task automatic send_range(input int lo, input int hi, input bit first,
                              input bit fin, input bit gaps);
        for (int i = lo; i <= hi; i++) begin
            if (gaps && $urandom_range(0, 3) == 0) idle_noise();
            put(1'b1, first && (i == lo), fin && (i == hi), msg[i]);
        end
    endtask

    // Cycle after the last byte: done and field, then done drops (R5)
    task automatic finish_check(input string req, input logic [103:0] exp);
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
        chk_bit({req, " R5 done pulse"}, ecc_done, 1'b1);
        chk_vec(req, ecc_out, exp);
        @(negedge clk);
        chk_bit("R5 done drops", ecc_done, 1'b0);
        chk_vec("R6 field holds", ecc_out, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [103:0] exp_a;
        logic [103:0] exp_b;
        void'($urandom(32'd24681));
        gen = tb_generator();

        // R1: reset state
        repeat (4) @(negedge clk);
        chk_vec("R1 reset field", ecc_out, '0);
        chk_bit("R1 reset done", ecc_done, 1'b0);
        rst_n = 1'b1;

        // R9: zero sector gives the mask exactly
        for (int i = 0; i < 512; i++) msg[i] = 8'h00;
        send_range(0, 511, 1'b1, 1'b1, 1'b0);
        finish_check("R9 zero sector", TB_MASK);

        // R2: erased sector against the model
        for (int i = 0; i < 512; i++) msg[i] = 8'hff;
        send_range(0, 511, 1'b1, 1'b1, 1'b0);
        finish_check("R2 all-ones sector", ref_ecc(512));

        // R2: bit order, single set bit at the first and at the final position
        for (int i = 0; i < 512; i++) msg[i] = 8'h00;
        msg[0] = 8'h80;
        send_range(0, 511, 1'b1, 1'b1, 1'b0);
        finish_check("R2 leading bit", ref_ecc(512));
        msg[0] = 8'h00; msg[511] = 8'h01;
        send_range(0, 511, 1'b1, 1'b1, 1'b0);
        finish_check("R2 trailing bit", ref_ecc(512));

        // R2 and R4: random sectors with noisy idle gaps
        for (int s = 0; s < 6; s++) begin
            for (int i = 0; i < 512; i++) msg[i] = 8'($urandom);
            send_range(0, 511, 1'b1, 1'b1, 1'b1);
            finish_check("R2 R4 random sector", ref_ecc(512));
        end

        // R4: idle beats with both flags high leave everything untouched
        exp_a = ecc_out;
        for (int i = 0; i < 5; i++) put(1'b0, 1'b1, 1'b1, 8'($urandom));
        @(negedge clk);
        in_start = 1'b0; in_last = 1'b0;
        chk_bit("R4 no done on idle", ecc_done, 1'b0);
        chk_vec("R4 field untouched", ecc_out, exp_a);

        // R3 and R6: garbage without start, then a fresh sector; field holds mid-way
        for (int i = 0; i < 40; i++) msg[i] = 8'($urandom);
        send_range(0, 39, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 512; i++) msg[i] = 8'($urandom);
        send_range(0, 199, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk_vec("R6 field held during next sector", ecc_out, exp_a);
        send_range(200, 511, 1'b0, 1'b1, 1'b1);
        finish_check("R3 start clears", ref_ecc(512));

        // R7: one-byte sectors
        msg[0] = 8'h00;
        send_range(0, 0, 1'b1, 1'b1, 1'b0);
        finish_check("R7 single zero byte", TB_MASK);
        msg[0] = 8'h5a;
        send_range(0, 0, 1'b1, 1'b1, 1'b0);
        finish_check("R7 single byte", ref_ecc(1));

        // R8: next start accepted on the done cycle of the previous sector
        for (int i = 0; i < 64; i++) msg[i] = 8'($urandom);
        exp_a = ref_ecc(64);
        send_range(0, 63, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 512; i++) msg[i] = 8'($urandom);
        exp_b = ref_ecc(512);
        @(negedge clk);
        chk_bit("R8 done with next start", ecc_done, 1'b1);
        chk_vec("R8 first sector", ecc_out, exp_a);
        in_valid = 1'b1; in_start = 1'b1; in_last = 1'b0; in_byte = msg[0];
        send_range(1, 511, 1'b0, 1'b1, 1'b1);
        finish_check("R8 second sector", exp_b);

        finish_run();
    end

endmodule